// File: doc/BRIEF.md
# I3C Controller Transfer Queue Front End

This block sits between software and the bus engine of an I3C bus controller. Software describes each transfer as a pair of 32-bit words written one after the other into a single command port: an argument word (attribute code, data length) followed by the command word (transaction ID, device index, read flag and the other per-transfer fields). Only the second write places a complete entry in the command queue. A bus engine stub takes entries from that queue one at a time. After a fixed latency it returns one response word per command, and software pops these responses through a read port. The stub's error code and read length come from two input ports, so every completion outcome can be produced without a real bus.

The block raises an interrupt when the response queue fills past a programmed threshold and when a transfer finishes with an error. Interrupt status goes through a visibility mask and then a signalling mask. After an error response the engine stops taking commands until software writes the resume bit. Software can flush the command or response queue by writing a reset register whose bits clear themselves once the flush is done.

Top module: `i3c_xfer_queue`

## Requirements
- R1: A write to the command port (word index 1) is held as the argument. The next write to the same port pushes one entry. After an odd number of writes the queue level (bits 7:0 of the level register, index 8) has not grown.
- R2: A response word holds the error code in bits 31:28, the transaction ID taken from command bits 6:3 in bits 27:24, and zero in bits 23:16. Its length in bits 15:0 is the stub read length if command bit 28 (read) is set, and zero otherwise.
- R3: Responses leave the response port (index 2) in the same order as their commands were pushed.
- R4: Bits 15:8 of the threshold register (index 3) hold the count minus one. Status bit 4 (response ready) is raw-active while the response level (level register bits 15:8) is greater than that field.
- R5: Status bit 9 (transfer error) is set by any response whose error code is nonzero. It stays set until bit 9 is written as 1 to the status register (index 5). A write with bit 9 at 0 leaves it set.
- R6: The status register reads raw status AND status-enable (index 6). The irq output is the OR of the visible status AND signal-enable (index 7).
- R7: After an error response the engine takes no further command until 1 is written to bit 30 of the control register (index 0). Bit 30 always reads back 0.
- R8: The engine takes commands only while control bit 31 (enable) is 1.
- R9: Reset register (index 4) bit 1 flushes the command queue and returns the word phase to "argument next". Bit 2 flushes the response queue. Bit 0 flushes both. A written bit reads 1 in the following cycle and 0 once its flush has happened one cycle later.
- R10: Popping an empty response queue returns 0 and leaves the response level unchanged.
- R11: After reset, both queue levels, the reset register, the control register, the visible status and irq are all 0.
- R12: A command pushed into a full command queue is dropped, so the level stays at the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops at the response port) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt line |
| stub_err | input | 4 | Error code the stub engine reports for the next completion |
| stub_len | input | 16 | Length the stub engine reports for a read completion |

## Verification
The bench writes the two command words separately and checks that a phase toggle which loses track shows up as an early entry in the level register. It does the same just after a command-queue flush, when a stale argument would pair with the next write. It halts the engine with an error while a second command waits, to catch an engine that keeps running or never resumes. It also counts responses one at a time across a threshold of three, to separate "greater than" from "greater or equal". Finally it pops an empty response queue, where a missing guard would make the level counter wrap to a large value.

// File: rtl/i3c_xq_pkg.sv
`timescale 1ns/1ps
package i3c_xq_pkg;

    localparam int WORD_W = 32;
    localparam int INT_W  = 10;
    localparam int RST_W  = 6;

    typedef enum logic [3:0] {
        REG_CTRL       = 4'd0,
        REG_CMD        = 4'd1,
        REG_RESP       = 4'd2,
        REG_THLD       = 4'd3,
        REG_RESET      = 4'd4,
        REG_INT_STS    = 4'd5,
        REG_INT_STS_EN = 4'd6,
        REG_INT_SIG_EN = 4'd7,
        REG_QLEVEL     = 4'd8
    } reg_sel_e;

    localparam int CTRL_ENABLE  = 31;
    localparam int CTRL_RESUME  = 30;
    localparam int INT_RESP_RDY = 4;
    localparam int INT_XFER_ERR = 9;
    localparam int RST_SOFT     = 0;
    localparam int RST_CMDQ     = 1;
    localparam int RST_RESPQ    = 2;

    typedef enum logic [3:0] {
        ERR_NONE       = 4'd0,
        ERR_CRC        = 4'd1,
        ERR_PARITY     = 4'd2,
        ERR_FRAME      = 4'd3,
        ERR_BCAST_NACK = 4'd4,
        ERR_ADDR_NACK  = 4'd5,
        ERR_OVF_UNF    = 4'd6,
        ERR_ABORTED    = 4'd8,
        ERR_I2C_WNACK  = 4'd9
    } xfer_err_e;

    typedef struct packed {
        logic [WORD_W-1:0] arg;
        logic [WORD_W-1:0] cmd;
    } cmd_entry_t;

    typedef struct packed {
        logic [3:0]  err;
        logic [3:0]  tid;
        logic [7:0]  rsvd;
        logic [15:0] len;
    } resp_word_t;

    function automatic logic [3:0] cmd_tid(input logic [WORD_W-1:0] w);
        return w[6:3];
    endfunction

    function automatic logic cmd_is_read(input logic [WORD_W-1:0] w);
        return w[28];
    endfunction

    function automatic resp_word_t build_resp(input cmd_entry_t c,
                                              input logic [3:0] err,
                                              input logic [15:0] rd_len);
        resp_word_t r;
        r.err  = err;
        r.tid  = cmd_tid(c.cmd);
        r.rsvd = '0;
        r.len  = cmd_is_read(c.cmd) ? rd_len : 16'd0;
        return r;
    endfunction

endpackage

// File: rtl/i3c_xq_fifo.sv
`timescale 1ns/1ps
module i3c_xq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == FULL_LVL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i3c_xq_engine_stub.sv
`timescale 1ns/1ps
module i3c_xq_engine_stub
    import i3c_xq_pkg::*;
#(
    parameter int LATENCY = 3,
    localparam int CNT_W = $clog2(LATENCY + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        resume,
    input  logic        cmd_avail,
    input  cmd_entry_t  cmd_in,
    output logic        cmd_pop,
    input  logic        resp_full,
    output logic        resp_push,
    output resp_word_t  resp_out,
    input  logic [3:0]  stub_err,
    input  logic [15:0] stub_len,
    output logic        halted
);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    cmd_entry_t       cur;
    logic             unused_fields;

    assign cmd_pop   = !busy && enable && !halted && cmd_avail;
    assign resp_push = busy && (cnt == '0) && !resp_full;
    assign resp_out  = build_resp(cur, stub_err, stub_len);

    // Fields a real bus engine would act on; the stub only echoes the ID.
    assign unused_fields = ^{cur.arg, cur.cmd[31:29], cur.cmd[27:7], cur.cmd[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cur    <= '0;
            halted <= 1'b0;
        end else begin
            if (cmd_pop) begin
                busy <= 1'b1;
                cur  <= cmd_in;
                cnt  <= CNT_W'(LATENCY);
            end else if (busy) begin
                if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                end else if (!resp_full) begin
                    busy <= 1'b0;
                end
            end
            if (resp_push && (stub_err != 4'd0)) begin
                halted <= 1'b1;
            end else if (resume) begin
                halted <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i3c_xq_regs.sv
`timescale 1ns/1ps
module i3c_xq_regs
    import i3c_xq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [7:0]        cmd_level,
    input  logic [7:0]        resp_level,
    input  resp_word_t        resp_head,
    input  logic              resp_empty,
    input  logic              err_event,
    output logic              cmd_push,
    output cmd_entry_t        cmd_entry,
    output logic              resp_pop,
    output logic              flush_cmdq,
    output logic              flush_respq,
    output logic              eng_enable,
    output logic              eng_resume,
    output logic [RST_W-1:0]  rst_bits,
    output logic [INT_W-1:0]  int_raw,
    output logic              irq
);

    reg_sel_e          sel;
    logic              wr_ctrl, wr_cmd, wr_thld, wr_reset, wr_sts, wr_sts_en, wr_sig_en;
    logic              word_phase;
    logic [WORD_W-1:0] arg_q;
    logic [7:0]        thld_q;
    logic [INT_W-1:0]  sts_en_q, sig_en_q, visible;
    logic              err_sticky;

    assign sel       = reg_sel_e'(addr);
    assign wr_ctrl   = wr_en && (sel == REG_CTRL);
    assign wr_cmd    = wr_en && (sel == REG_CMD);
    assign wr_thld   = wr_en && (sel == REG_THLD);
    assign wr_reset  = wr_en && (sel == REG_RESET);
    assign wr_sts    = wr_en && (sel == REG_INT_STS);
    assign wr_sts_en = wr_en && (sel == REG_INT_STS_EN);
    assign wr_sig_en = wr_en && (sel == REG_INT_SIG_EN);

    assign flush_cmdq  = rst_bits[RST_CMDQ]  || rst_bits[RST_SOFT];
    assign flush_respq = rst_bits[RST_RESPQ] || rst_bits[RST_SOFT];

    // Two-word command assembly
    assign cmd_push      = wr_cmd && word_phase && !flush_cmdq;
    assign cmd_entry.arg = arg_q;
    assign cmd_entry.cmd = wdata;

    always_ff @(posedge clk) begin
        if (rst || flush_cmdq) begin
            word_phase <= 1'b0;
            arg_q      <= '0;
        end else if (wr_cmd) begin
            word_phase <= !word_phase;
            if (!word_phase) arg_q <= wdata;
        end
    end

    assign resp_pop   = rd_en && (sel == REG_RESP) && !resp_empty;
    assign eng_resume = wr_ctrl && wdata[CTRL_RESUME];

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_enable <= 1'b0;
            thld_q     <= '0;
            sts_en_q   <= '0;
            sig_en_q   <= '0;
            rst_bits   <= '0;
            err_sticky <= 1'b0;
        end else begin
            if (wr_ctrl)   eng_enable <= wdata[CTRL_ENABLE];
            if (wr_thld)   thld_q     <= wdata[15:8];
            if (wr_sts_en) sts_en_q   <= wdata[INT_W-1:0];
            if (wr_sig_en) sig_en_q   <= wdata[INT_W-1:0];
            rst_bits <= wr_reset ? wdata[RST_W-1:0] : '0;
            if (err_event) begin
                err_sticky <= 1'b1;
            end else if (wr_sts && wdata[INT_XFER_ERR]) begin
                err_sticky <= 1'b0;
            end
        end
    end

    always_comb begin
        int_raw               = '0;
        int_raw[INT_RESP_RDY] = (resp_level > thld_q);
        int_raw[INT_XFER_ERR] = err_sticky;
    end

    assign visible = int_raw & sts_en_q;
    assign irq     = |(visible & sig_en_q);

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL:       rdata[CTRL_ENABLE] = eng_enable;
            REG_RESP:       rdata = resp_empty ? '0 : resp_head;
            REG_THLD:       rdata[15:8] = thld_q;
            REG_RESET:      rdata[RST_W-1:0] = rst_bits;
            REG_INT_STS:    rdata[INT_W-1:0] = visible;
            REG_INT_STS_EN: rdata[INT_W-1:0] = sts_en_q;
            REG_INT_SIG_EN: rdata[INT_W-1:0] = sig_en_q;
            REG_QLEVEL:     rdata[15:0] = {resp_level, cmd_level};
            default:        rdata = '0;
        endcase
    end

endmodule

// File: rtl/i3c_xfer_queue.sv
`timescale 1ns/1ps
module i3c_xfer_queue
    import i3c_xq_pkg::*;
#(
    parameter int CMD_DEPTH      = 4,
    parameter int RESP_DEPTH     = 4,
    parameter int ENGINE_LATENCY = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic [3:0]  stub_err,
    input  logic [15:0] stub_len
);

    localparam int CMD_W       = $bits(cmd_entry_t);
    localparam int RESP_W      = $bits(resp_word_t);
    localparam int CMD_LVL_W   = $clog2(CMD_DEPTH + 1);
    localparam int RESP_LVL_W  = $clog2(RESP_DEPTH + 1);

    cmd_entry_t             cmd_entry, cmd_head;
    logic [CMD_W-1:0]       cmd_head_raw;
    resp_word_t             resp_word, resp_head;
    logic [RESP_W-1:0]      resp_head_raw;
    logic                   cmd_push, cmd_pop, cmd_empty, cmd_full;
    logic                   resp_push, resp_pop, resp_empty, resp_full;
    logic [CMD_LVL_W-1:0]   cmd_level;
    logic [RESP_LVL_W-1:0]  resp_level;
    logic [7:0]             cmd_level8, resp_level8;
    logic                   flush_cmdq, flush_respq;
    logic                   eng_enable, eng_resume, eng_halted;
    logic [RST_W-1:0]       rst_bits;
    logic [INT_W-1:0]       int_raw;
    logic                   err_event;
    logic                   unused_full;

    assign cmd_level8  = 8'(cmd_level);
    assign resp_level8 = 8'(resp_level);
    assign cmd_head    = cmd_entry_t'(cmd_head_raw);
    assign resp_head   = resp_word_t'(resp_head_raw);
    assign err_event   = resp_push && (resp_word.err != 4'd0);
    assign unused_full = cmd_full;

    i3c_xq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr_en),
        .rd_en       (reg_rd_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .cmd_level   (cmd_level8),
        .resp_level  (resp_level8),
        .resp_head   (resp_head),
        .resp_empty  (resp_empty),
        .err_event   (err_event),
        .cmd_push    (cmd_push),
        .cmd_entry   (cmd_entry),
        .resp_pop    (resp_pop),
        .flush_cmdq  (flush_cmdq),
        .flush_respq (flush_respq),
        .eng_enable  (eng_enable),
        .eng_resume  (eng_resume),
        .rst_bits    (rst_bits),
        .int_raw     (int_raw),
        .irq         (irq)
    );

    i3c_xq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_cmdq),
        .push  (cmd_push),
        .din   (cmd_entry),
        .pop   (cmd_pop),
        .dout  (cmd_head_raw),
        .empty (cmd_empty),
        .full  (cmd_full),
        .level (cmd_level)
    );

    i3c_xq_fifo #(.WIDTH(RESP_W), .DEPTH(RESP_DEPTH)) u_resp_q (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_respq),
        .push  (resp_push),
        .din   (resp_word),
        .pop   (resp_pop),
        .dout  (resp_head_raw),
        .empty (resp_empty),
        .full  (resp_full),
        .level (resp_level)
    );

    i3c_xq_engine_stub #(.LATENCY(ENGINE_LATENCY)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .enable    (eng_enable),
        .resume    (eng_resume),
        .cmd_avail (!cmd_empty),
        .cmd_in    (cmd_head),
        .cmd_pop   (cmd_pop),
        .resp_full (resp_full),
        .resp_push (resp_push),
        .resp_out  (resp_word),
        .stub_err  (stub_err),
        .stub_len  (stub_len),
        .halted    (eng_halted)
    );

endmodule

// File: rtl/i3c_xq_checker.sv
`timescale 1ns/1ps
module i3c_xq_checker
    import i3c_xq_pkg::*;
#(
    parameter int RESP_DEPTH = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_pop,
    input logic        eng_halted,
    input logic        eng_enable,
    input logic        resp_push,
    input logic [3:0]  resp_err,
    input logic [7:0]  resp_level,
    input logic        resp_empty,
    input logic        rd_en,
    input logic        wr_en,
    input logic [3:0]  addr,
    input logic [31:0] wdata,
    input logic [5:0]  rst_bits,
    input logic [9:0]  int_raw
);

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        (resp_push && resp_err != 4'd0) |=> eng_halted) else $error("halt missing"); // R7

    AST_HALT_BLOCKS_POP: assert property (@(posedge clk) disable iff (rst)
        eng_halted |-> !cmd_pop) else $error("pop while halted"); // R7

    AST_DISABLED_NO_POP: assert property (@(posedge clk) disable iff (rst)
        !eng_enable |-> !cmd_pop) else $error("pop while disabled"); // R8

    AST_EMPTY_POP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_RESP && resp_empty && !resp_push) |=> $stable(resp_level))
        else $error("empty pop moved level"); // R10

    AST_RESET_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rst_bits != 6'd0 && !(wr_en && addr == REG_RESET)) |=> (rst_bits == 6'd0))
        else $error("reset bit stuck"); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (int_raw[INT_XFER_ERR] && !(wr_en && addr == REG_INT_STS && wdata[INT_XFER_ERR]))
        |=> int_raw[INT_XFER_ERR]) else $error("error status lost"); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        resp_level <= 8'(RESP_DEPTH)) else $error("response overflow"); // R3

endmodule

bind i3c_xfer_queue i3c_xq_checker #(.RESP_DEPTH(RESP_DEPTH)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .cmd_pop    (cmd_pop),
    .eng_halted (eng_halted),
    .eng_enable (eng_enable),
    .resp_push  (resp_push),
    .resp_err   (resp_word.err),
    .resp_level (resp_level8),
    .resp_empty (resp_empty),
    .rd_en      (reg_rd_en),
    .wr_en      (reg_wr_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rst_bits   (rst_bits),
    .int_raw    (int_raw)
);

// File: tb/test_i3c_xfer_queue.sv
`timescale 1ns/1ps
module test_i3c_xfer_queue;

    localparam logic [3:0] A_CTRL = 4'd0, A_CMD = 4'd1, A_RESP = 4'd2, A_THLD = 4'd3,
                           A_RESET = 4'd4, A_STS = 4'd5, A_STS_EN = 4'd6, A_SIG_EN = 4'd7,
                           A_LVL = 4'd8;
    localparam int NVEC = 6;
    // {tid[24:21], rd[20], err[19:16], len[15:0]}
    localparam logic [24:0] VECS [NVEC] = '{
        {4'd3,  1'b1, 4'd0, 16'h0010},
        {4'd7,  1'b0, 4'd0, 16'h1234},
        {4'd15, 1'b1, 4'd5, 16'hFFFF},
        {4'd0,  1'b1, 4'd0, 16'h8000},
        {4'd9,  1'b0, 4'd9, 16'h00AA},
        {4'd1,  1'b1, 4'd1, 16'h0004}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [3:0]  stub_err = '0;
    logic [15:0] stub_len = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    i3c_xfer_queue i_i3c_xfer_queue (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .stub_err(stub_err), .stub_len(stub_len)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_cmd(input logic [3:0] tid, input logic rd_flag, input logic [15:0] len);
        wr(A_CMD, {len, 13'd0, 3'd1});
        wr(A_CMD, (32'd1 << 30) | (32'(rd_flag) << 28) | (32'd1 << 15) | (32'(tid) << 3));
    endtask

    function automatic logic [31:0] exp_resp(input logic [3:0] e, input logic [3:0] t,
                                             input logic r, input logic [15:0] l);
        return {e, t, 8'h00, r ? l : 16'h0000};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        rd(A_LVL, rv);   check("R11 levels", rv, 32'h0);
        rd(A_STS, rv);   check("R11 status", rv, 32'h0);
        rd(A_RESET, rv); check("R11 reset reg", rv, 32'h0);
        rd(A_CTRL, rv);  check("R11 ctrl", rv, 32'h0);
        check("R11 irq", {31'd0, irq}, 32'h0);

        wr(A_STS_EN, 32'h210);
        wr(A_SIG_EN, 32'h210);

        // R1 two-word assembly, engine disabled (R8)
        wr(A_CMD, 32'h0000_0001);
        rd(A_LVL, rv); check("R1 after argument", rv, 32'h0);
        wr(A_CMD, (32'd1 << 15) | (32'd5 << 3));
        rd(A_LVL, rv); check("R1 after command", rv, 32'h1);
        idle(12);
        rd(A_LVL, rv); check("R8 disabled holds", rv, 32'h1);
        wr(A_CTRL, 32'h8000_0000);
        idle(12);
        rd(A_LVL, rv);  check("R8 enabled runs", rv, 32'h100);
        rd(A_RESP, rv); check("R2 write response", rv, 32'h0500_0000);

        // R2/R5 vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] t; logic r; logic [3:0] e; logic [15:0] l;
            {t, r, e, l} = VECS[i];
            stub_err = e; stub_len = l;
            push_cmd(t, r, 16'h0020);
            idle(12);
            rd(A_LVL, rv);  check("R2 level", rv, 32'h100);
            rd(A_RESP, rv); check("R2 response", rv, exp_resp(e, t, r, l));
            rd(A_STS, rv);
            if (e != 4'd0) begin
                check("R5 error set", rv, 32'h200);
                check("R6 irq on error", {31'd0, irq}, 32'h1);
                wr(A_STS, 32'h010);
                rd(A_STS, rv); check("R5 write zero keeps", rv, 32'h200);
                wr(A_STS, 32'h200);
                rd(A_STS, rv); check("R5 cleared", rv, 32'h0);
                wr(A_CTRL, 32'hC000_0000);
            end else begin
                check("R5 no error", rv, 32'h0);
            end
        end
        stub_err = 4'd0;

        // R7 halt after error
        stub_err = 4'd2;
        push_cmd(4'd1, 1'b0, 16'h1);
        idle(12);
        stub_err = 4'd0;
        push_cmd(4'd2, 1'b0, 16'h1);
        idle(12);
        rd(A_LVL, rv);  check("R7 halted", rv, 32'h101);
        rd(A_RESP, rv); check("R7 error response", rv, 32'h2100_0000);
        wr(A_STS, 32'h200);
        wr(A_CTRL, 32'hC000_0000);
        rd(A_CTRL, rv); check("R7 resume reads 0", rv, 32'h8000_0000);
        idle(12);
        rd(A_LVL, rv);  check("R7 resumed", rv, 32'h100);
        rd(A_RESP, rv); check("R7 held command", rv, 32'h0200_0000);

        // R4 threshold of three, R3 order
        wr(A_THLD, 32'h200);
        stub_len = 16'h0001;
        push_cmd(4'd10, 1'b1, 16'h1); idle(12);
        rd(A_STS, rv); check("R4 one below", rv, 32'h0);
        push_cmd(4'd11, 1'b1, 16'h1); idle(12);
        rd(A_STS, rv); check("R4 two below", rv, 32'h0);
        check("R4 irq low", {31'd0, irq}, 32'h0);
        push_cmd(4'd12, 1'b1, 16'h1); idle(12);
        rd(A_STS, rv); check("R4 at three", rv, 32'h010);
        check("R4 irq high", {31'd0, irq}, 32'h1);
        rd(A_LVL, rv);  check("R3 level", rv, 32'h300);
        rd(A_RESP, rv); check("R3 first", rv, 32'h0A00_0001);
        rd(A_RESP, rv); check("R3 second", rv, 32'h0B00_0001);
        rd(A_RESP, rv); check("R3 third", rv, 32'h0C00_0001);
        wr(A_THLD, 32'h0);

        // R6 masks
        push_cmd(4'd4, 1'b0, 16'h1); idle(12);
        wr(A_STS_EN, 32'h0);
        rd(A_STS, rv); check("R6 hidden", rv, 32'h0);
        check("R6 irq hidden", {31'd0, irq}, 32'h0);
        wr(A_STS_EN, 32'h210);
        wr(A_SIG_EN, 32'h0);
        rd(A_STS, rv); check("R6 visible", rv, 32'h010);
        check("R6 irq unsignalled", {31'd0, irq}, 32'h0);
        wr(A_SIG_EN, 32'h210);
        #1 check("R6 irq signalled", {31'd0, irq}, 32'h1);
        rd(A_RESP, rv); check("R6 response", rv, 32'h0400_0000);

        // R10 empty pop
        rd(A_RESP, rv); check("R10 empty data", rv, 32'h0);
        rd(A_LVL, rv);  check("R10 level", rv, 32'h0);
        rd(A_RESP, rv); check("R10 empty again", rv, 32'h0);
        rd(A_LVL, rv);  check("R10 level again", rv, 32'h0);

        // R12 full drop, R9 flushes
        wr(A_CTRL, 32'h0);
        for (int k = 0; k < 5; k++) push_cmd(4'(k), 1'b0, 16'h1);
        rd(A_LVL, rv); check("R12 saturates", rv, 32'h4);
        wr(A_CMD, 32'h0000_0001);
        wr(A_RESET, 32'h2);
        rd(A_RESET, rv); check("R9 bit visible", rv, 32'h2);
        rd(A_RESET, rv); check("R9 self clear", rv, 32'h0);
        rd(A_LVL, rv);   check("R9 cmd flushed", rv, 32'h0);
        wr(A_CMD, 32'h0000_0001);
        rd(A_LVL, rv);   check("R9 phase reset", rv, 32'h0);
        wr(A_CMD, (32'd1 << 15) | (32'd6 << 3));
        rd(A_LVL, rv);   check("R9 pair after flush", rv, 32'h1);
        wr(A_CTRL, 32'h8000_0000);
        idle(12);
        rd(A_LVL, rv);   check("R9 response present", rv, 32'h100);
        wr(A_RESET, 32'h4);
        rd(A_RESET, rv); check("R9 resp bit visible", rv, 32'h4);
        rd(A_LVL, rv);   check("R9 resp flushed", rv, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule